// File: doc/BRIEF.md
# DDR2 Column Command Spacing Guard

This block sits between the command scheduler of a DDR2 memory controller and the path to the memory. Each cycle the scheduler may offer one column command, a read or a write to a numbered bank. The guard answers in the same cycle: it grants the command, holds it off, or flags it as an error. A held-off command simply stays offered. Every cycle in which nothing is granted is a no-operation slot on the memory command bus.

Spacing comes from a small programmed timing set: additive latency, CAS latency and a burst length of 4 or 8. From these the guard derives the read latency (additive plus CAS) and the write latency, which is always one clock below the read latency. Both are presented as outputs for the data path. After a granted read, a following read must wait 2 clocks at burst 4 or 4 clocks at burst 8, whatever the bank. This lets consecutive read bursts stream without gaps. A following write must wait 4 clocks at burst 4 or 6 clocks at burst 8.

The guard also records which banks are open, from the activate and precharge strobes the scheduler issues. A column command to a closed bank is never granted and raises an error for that cycle.

Top module: `colCmdGuard`

## Requirements
- R1: `readLatency` equals the stored additive latency plus the stored CAS latency, and `writeLatency` equals `readLatency` minus one. For example, AL=2 and CL=3 give 5 and 4.
- R2: After reset all banks are closed and the stored configuration is AL=0, CL=3 and burst 4. The latency outputs therefore read 3 and 2, and no command is granted.
- R3: The configuration inputs are stored at a clock edge only when the block is idle. Idle means that no read spacing window from an earlier read is still running and `cmdValid` is low. Values presented while the block is not idle have no effect on the outputs until they are presented in an idle cycle.
- R4: A configuration with `cfgAl` above 4, or with `cfgCl` below 3 or above 6, is never stored. The previous configuration stays in force.
- R5: After a read is granted in cycle t, no read is granted before cycle t+2 with burst 4 (`cfgBurst8`=0), or before cycle t+4 with burst 8 (`cfgBurst8`=1). This holds for any pair of banks. A read to an open bank is granted as soon as that spacing has elapsed.
- R6: After a read is granted in cycle t, no write is granted before cycle t+4 with burst 4 or t+6 with burst 8. A write to an open bank is granted as soon as that spacing has elapsed.
- R7: A granted write starts no spacing window. A write or a read to an open bank in the very next cycle is granted, subject only to windows started by earlier reads.
- R8: A command to a closed bank raises `cmdError` in that cycle and is not granted. It also starts no spacing window. `cmdError` is never high together with `cmdReady`, and it is low when `cmdValid` is low.
- R9: An activate opens its bank and a precharge closes its bank, both from the next cycle on. A command in the same cycle as the strobe sees the old state. When an activate and a precharge name the same bank in one cycle, the bank ends closed.
- R10: The grant is combinational. `cmdReady` is high in the same cycle as `cmdValid` whenever the target bank is open and the spacing rules allow the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAl | input | 3 | Requested additive latency (0 to 4) |
| cfgCl | input | 3 | Requested CAS latency (3 to 6) |
| cfgBurst8 | input | 1 | Requested burst length: 1 for 8, 0 for 4 |
| actValid | input | 1 | Activate strobe |
| actBank | input | 2 | Bank opened by the activate |
| preValid | input | 1 | Precharge strobe |
| preBank | input | 2 | Bank closed by the precharge |
| cmdValid | input | 1 | A column command is offered |
| cmdWrite | input | 1 | Offered command is a write (0 = read) |
| cmdBank | input | 2 | Bank of the offered command |
| cmdReady | output | 1 | Grant for the offered command this cycle |
| cmdError | output | 1 | Offered command targets a closed bank |
| readLatency | output | 4 | Derived read latency in clocks |
| writeLatency | output | 4 | Derived write latency in clocks |

## Verification
The hardest situation to reach from the ports is a configuration change offered while a spacing window is still running. Only then does the idle condition decide whether the new burst length takes effect. The stimulus grants a read and then, in the next cycle, presents a new burst length with no command offered. The new setting must stay out of force until the turnaround window has drained, and the bench checks the latency outputs on every cycle of that stretch. Reads and writes are then held valid across whole windows at both burst lengths, so the exact first cycle of each grant is compared against the reference model.

// File: rtl/colGuardPkg.sv
package colGuardPkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadRead;   // a read was granted this cycle: start spacing windows
    logic loadCfg;    // block is idle: configuration may be captured
  } guardStrobe_t;

endpackage

// File: rtl/colGuardBanks.sv
module colGuardBanks #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 actValid,
  input  logic [BANK_W-1:0]    actBank,
  input  logic                 preValid,
  input  logic [BANK_W-1:0]    preBank,
  output logic [NUM_BANKS-1:0] bankOpen
);

  logic [NUM_BANKS-1:0] openQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitAct;
    logic hitPre;
    assign hitAct = actValid && (actBank == BANK_W'(b));
    assign hitPre = preValid && (preBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ[b] <= 1'b0;
      end else if (hitPre) begin
        openQ[b] <= 1'b0;   // precharge takes priority over activate
      end else if (hitAct) begin
        openQ[b] <= 1'b1;
      end
    end
  end

  assign bankOpen = openQ;

  assert_act_opens_R9: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && !(preValid && preBank == actBank)) |=> bankOpen[$past(actBank)]);

  assert_pre_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    preValid |=> !bankOpen[$past(preBank)]);

endmodule

// File: rtl/colGuardDp.sv
module colGuardDp
  import colGuardPkg::*;
#(
  parameter int AL_W          = 3,
  parameter int CL_W          = 3,
  parameter int AL_MAX        = 4,
  parameter int CL_MIN        = 3,
  parameter int CL_MAX        = 6,
  parameter int RR_GAP_SHORT  = 2,
  parameter int RR_GAP_LONG   = 4,
  parameter int RTW_GAP_SHORT = 4,
  parameter int RTW_GAP_LONG  = 6,
  localparam int LAT_W = $clog2(AL_MAX + CL_MAX + 1),
  localparam int CNT_W = $clog2(RTW_GAP_LONG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  guardStrobe_t     strobe,
  input  logic [AL_W-1:0]  cfgAl,
  input  logic [CL_W-1:0]  cfgCl,
  input  logic             cfgBurst8,
  output logic             rrFree,
  output logic             rtwFree,
  output logic [LAT_W-1:0] readLatency,
  output logic [LAT_W-1:0] writeLatency
);

  logic [AL_W-1:0]  alQ;
  logic [CL_W-1:0]  clQ;
  logic             bl8Q;
  logic [CNT_W-1:0] rrCnt;
  logic [CNT_W-1:0] rtwCnt;
  logic             cfgOk;
  logic [CNT_W-1:0] rrLoad;
  logic [CNT_W-1:0] rtwLoad;

  // Range check on the requested configuration.
  always_comb begin
    cfgOk = (cfgAl <= AL_W'(AL_MAX)) &&
            (cfgCl >= CL_W'(CL_MIN)) &&
            (cfgCl <= CL_W'(CL_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alQ  <= '0;
      clQ  <= CL_W'(CL_MIN);
      bl8Q <= 1'b0;
    end else if (strobe.loadCfg && cfgOk) begin
      alQ  <= cfgAl;
      clQ  <= cfgCl;
      bl8Q <= cfgBurst8;
    end
  end

  // Window lengths minus one: the counter reads zero once the gap elapses.
  always_comb begin
    rrLoad  = bl8Q ? CNT_W'(RR_GAP_LONG - 1)  : CNT_W'(RR_GAP_SHORT - 1);
    rtwLoad = bl8Q ? CNT_W'(RTW_GAP_LONG - 1) : CNT_W'(RTW_GAP_SHORT - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrCnt  <= '0;
      rtwCnt <= '0;
    end else if (strobe.loadRead) begin
      rrCnt  <= rrLoad;
      rtwCnt <= rtwLoad;
    end else begin
      if (rrCnt != '0)  rrCnt  <= rrCnt - 1'b1;
      if (rtwCnt != '0) rtwCnt <= rtwCnt - 1'b1;
    end
  end

  assign rrFree       = (rrCnt == '0);
  assign rtwFree      = (rtwCnt == '0);
  assign readLatency  = LAT_W'(alQ) + LAT_W'(clQ);
  assign writeLatency = readLatency - 1'b1;

  assert_rl_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (readLatency >= LAT_W'(CL_MIN)) && (readLatency <= LAT_W'(AL_MAX + CL_MAX)));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rtwFree |=> ($stable(bl8Q) && $stable(readLatency)));

  assert_rr_within_rtw_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rrFree |-> !rtwFree);

endmodule

// File: rtl/colGuardCtrl.sv
module colGuardCtrl
  import colGuardPkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdWrite,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 rrFree,
  input  logic                 rtwFree,
  output logic                 cmdReady,
  output logic                 cmdError,
  output guardStrobe_t         strobe
);

  logic targetOpen;
  logic spacingOk;

  always_comb begin
    targetOpen      = bankOpen[cmdBank];
    spacingOk       = cmdWrite ? rtwFree : rrFree;
    cmdReady        = cmdValid && targetOpen && spacingOk;
    cmdError        = cmdValid && !targetOpen;
    strobe.loadRead = cmdReady && !cmdWrite;
    strobe.loadCfg  = !cmdValid && rrFree && rtwFree;
  end

  assert_ready_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && cmdError));

  assert_rd_rd_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdWrite) |=> !(cmdReady && !cmdWrite));

  assert_rd_wr_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdWrite) |=> !(cmdReady && cmdWrite));

  assert_err_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> cmdValid);

endmodule

// File: rtl/colCmdGuard.sv
module colCmdGuard
  import colGuardPkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int AL_W          = 3,
  parameter int CL_W          = 3,
  parameter int AL_MAX        = 4,
  parameter int CL_MIN        = 3,
  parameter int CL_MAX        = 6,
  parameter int RR_GAP_SHORT  = 2,
  parameter int RR_GAP_LONG   = 4,
  parameter int RTW_GAP_SHORT = 4,
  parameter int RTW_GAP_LONG  = 6,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int LAT_W  = $clog2(AL_MAX + CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AL_W-1:0]   cfgAl,
  input  logic [CL_W-1:0]   cfgCl,
  input  logic              cfgBurst8,
  input  logic              actValid,
  input  logic [BANK_W-1:0] actBank,
  input  logic              preValid,
  input  logic [BANK_W-1:0] preBank,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [BANK_W-1:0] cmdBank,
  output logic              cmdReady,
  output logic              cmdError,
  output logic [LAT_W-1:0]  readLatency,
  output logic [LAT_W-1:0]  writeLatency
);

  guardStrobe_t         strobe;
  logic [NUM_BANKS-1:0] bankOpen;
  logic                 rrFree;
  logic                 rtwFree;

  colGuardBanks #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk      (clk),
    .rstN     (rstN),
    .actValid (actValid),
    .actBank  (actBank),
    .preValid (preValid),
    .preBank  (preBank),
    .bankOpen (bankOpen)
  );

  colGuardCtrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdBank  (cmdBank),
    .bankOpen (bankOpen),
    .rrFree   (rrFree),
    .rtwFree  (rtwFree),
    .cmdReady (cmdReady),
    .cmdError (cmdError),
    .strobe   (strobe)
  );

  colGuardDp #(
    .AL_W          (AL_W),
    .CL_W          (CL_W),
    .AL_MAX        (AL_MAX),
    .CL_MIN        (CL_MIN),
    .CL_MAX        (CL_MAX),
    .RR_GAP_SHORT  (RR_GAP_SHORT),
    .RR_GAP_LONG   (RR_GAP_LONG),
    .RTW_GAP_SHORT (RTW_GAP_SHORT),
    .RTW_GAP_LONG  (RTW_GAP_LONG)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgAl        (cfgAl),
    .cfgCl        (cfgCl),
    .cfgBurst8    (cfgBurst8),
    .rrFree       (rrFree),
    .rtwFree      (rtwFree),
    .readLatency  (readLatency),
    .writeLatency (writeLatency)
  );

endmodule

// File: tb/colCmdGuard_tb.sv
module colCmdGuard_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cfgAl = 3'd0;
  logic [2:0] cfgCl = 3'd3;
  logic       cfgBurst8 = 1'b0;
  logic       actValid = 1'b0;
  logic [1:0] actBank = 2'd0;
  logic       preValid = 1'b0;
  logic [1:0] preBank = 2'd0;
  logic       cmdValid = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [1:0] cmdBank = 2'd0;
  logic       cmdReady;
  logic       cmdError;
  logic [3:0] readLatency;
  logic [3:0] writeLatency;

  always #(CLK_PERIOD / 2) clk = ~clk;

  colCmdGuard u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .cfgAl        (cfgAl),
    .cfgCl        (cfgCl),
    .cfgBurst8    (cfgBurst8),
    .actValid     (actValid),
    .actBank      (actBank),
    .preValid     (preValid),
    .preBank      (preBank),
    .cmdValid     (cmdValid),
    .cmdWrite     (cmdWrite),
    .cmdBank      (cmdBank),
    .cmdReady     (cmdReady),
    .cmdError     (cmdError),
    .readLatency  (readLatency),
    .writeLatency (writeLatency)
  );

  int    errors = 0;
  int    checks = 0;
  string req = "R2";

  // Behavioural reference state.
  int cyc = 0;
  int lastRd = -100;
  int mAl = 0;
  int mCl = 3;
  bit mBl8 = 0;
  bit mOpen [4] = '{0, 0, 0, 0};
  bit expReady;
  bit expErr;

  function automatic int rrGap(bit b8);
    return b8 ? 4 : 2;
  endfunction

  function automatic int rtwGap(bit b8);
    return b8 ? 6 : 4;
  endfunction

  // Called at a negedge with inputs already driven.
  task automatic tick();
    int expRl;
    int gap;
    #2;
    gap = cmdWrite ? rtwGap(mBl8) : rrGap(mBl8);
    expErr   = cmdValid && !mOpen[cmdBank];
    expReady = cmdValid && mOpen[cmdBank] && ((cyc - lastRd) >= gap);
    expRl    = mAl + mCl;
    checks++;
    if (cmdReady !== expReady || cmdError !== expErr ||
        int'(readLatency) != expRl || int'(writeLatency) != expRl - 1) begin
      errors++;
      $display("FAIL %s cyc=%0d: ready=%0b err=%0b rl=%0d wl=%0d expected ready=%0b err=%0b rl=%0d wl=%0d",
               req, cyc, cmdReady, cmdError, readLatency, writeLatency,
               expReady, expErr, expRl, expRl - 1);
    end
    @(posedge clk);
    if (expReady && !cmdWrite) lastRd = cyc;
    if (!cmdValid && ((cyc - lastRd) >= rtwGap(mBl8)) &&
        cfgAl <= 3'd4 && cfgCl >= 3'd3 && cfgCl <= 3'd6) begin
      mAl  = int'(cfgAl);
      mCl  = int'(cfgCl);
      mBl8 = cfgBurst8;
    end
    if (actValid) mOpen[actBank] = 1'b1;
    if (preValid) mOpen[preBank] = 1'b0;
    cyc++;
    @(negedge clk);
    actValid = 1'b0;
    preValid = 1'b0;
  endtask

  task automatic offer(bit v, bit w, logic [1:0] b);
    cmdValid = v;
    cmdWrite = w;
    cmdBank  = b;
  endtask

  task automatic idle(int n);
    offer(0, 0, 2'd0);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state, explicit constants
    req = "R2";
    #2;
    checks++;
    if (readLatency !== 4'd3 || writeLatency !== 4'd2 || cmdReady !== 1'b0) begin
      errors++;
      $display("FAIL R2: rl=%0d wl=%0d ready=%0b expected rl=3 wl=2 ready=0",
               readLatency, writeLatency, cmdReady);
    end
    @(negedge clk);
    idle(2);

    // R8: closed bank
    req = "R8";
    offer(1, 0, 2'd0); tick();
    offer(1, 1, 2'd2); tick();
    offer(1, 0, 2'd0); tick();   // still closed, no window started
    idle(1);

    // R9: activate takes effect next cycle
    req = "R9";
    actValid = 1'b1; actBank = 2'd0;
    offer(1, 0, 2'd0); tick();
    req = "R10";
    offer(1, 0, 2'd0); tick();
    req = "R9";
    actValid = 1'b1; actBank = 2'd1; offer(0, 0, 2'd0); tick();
    actValid = 1'b1; actBank = 2'd2; tick();
    actValid = 1'b1; actBank = 2'd3; tick();

    // R1: latency derivation
    req = "R1";
    cfgAl = 3'd2; cfgCl = 3'd3; cfgBurst8 = 1'b0;
    idle(4);

    // R5: reads held valid across banks, burst 4
    req = "R5";
    for (int i = 0; i < 10; i++) begin
      offer(1, 0, 2'(i % 4));
      tick();
    end
    idle(4);

    // R6: read then writes held, burst 4
    req = "R6";
    offer(1, 0, 2'd1); tick();
    for (int i = 0; i < 6; i++) begin
      offer(1, 1, 2'd2);
      tick();
    end
    idle(4);

    // R7: writes open no window
    req = "R7";
    offer(1, 1, 2'd0); tick();
    offer(1, 1, 2'd1); tick();
    offer(1, 1, 2'd3); tick();
    offer(1, 0, 2'd3); tick();
    offer(1, 1, 2'd0); tick();
    idle(4);

    // R3: configuration offered while a window runs
    req = "R3";
    offer(1, 0, 2'd0); tick();
    cfgAl = 3'd1; cfgCl = 3'd4; cfgBurst8 = 1'b1;
    idle(2);
    offer(1, 0, 2'd1); tick();   // busy: valid high, keeps old burst
    offer(1, 0, 2'd1); tick();
    idle(6);

    // R5 and R6 with burst 8
    req = "R5";
    for (int i = 0; i < 12; i++) begin
      offer(1, 0, 2'(3 - (i % 4)));
      tick();
    end
    idle(6);
    req = "R6";
    offer(1, 0, 2'd2); tick();
    for (int i = 0; i < 8; i++) begin
      offer(1, 1, 2'd0);
      tick();
    end
    idle(6);

    // R4: out-of-range configurations ignored
    req = "R4";
    cfgAl = 3'd5; cfgCl = 3'd4; idle(3);
    cfgAl = 3'd0; cfgCl = 3'd7; idle(3);
    cfgAl = 3'd3; cfgCl = 3'd2; idle(3);
    req = "R1";
    cfgAl = 3'd4; cfgCl = 3'd6; cfgBurst8 = 1'b0; idle(3);

    // R9: precharge wins over activate, then reopen
    req = "R9";
    preValid = 1'b1; preBank = 2'd1; actValid = 1'b1; actBank = 2'd1;
    offer(1, 0, 2'd1); tick();
    offer(1, 0, 2'd1); tick();
    preValid = 1'b1; preBank = 2'd2; offer(1, 1, 2'd2); tick();
    offer(1, 1, 2'd2); tick();
    actValid = 1'b1; actBank = 2'd2; offer(0, 0, 2'd0); tick();
    offer(1, 1, 2'd2); tick();
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule